// File: doc/BRIEF.md
# DMA Channel Loop Sequencer

This block is the control engine of a single DMA channel. A minor loop is one run of read/write pairs that moves a programmed byte count, one beat per pair. Each finished minor loop steps a current iteration counter down by one. When that counter runs out, the major loop is complete: the counter reloads from the beginning count and a sticky done flag sets. Along the way the sequencer can raise one-cycle interrupt pulses for the half-way point and for major completion. It can emit a link pulse that names another channel. It can also hold the bus idle for a programmed number of cycles after every access, which limits the bandwidth the channel takes.

A minor loop starts on a hardware request while the request enable is set, or on a software start pulse. Read and write requests are levels. Each one stays high until the bus side answers with a one-cycle completion. Address generation, the bus protocol itself and arbitration between channels are done elsewhere. The configuration inputs are expected to stay stable while a minor loop runs.

Top module: `dma_loop_seq`

## Requirements
- R1: After reset the sequencer is idle with busy, rd_req, wr_req, wr_buf, req_en, done_flag, all pulse outputs and citer at zero.
- R2: A minor loop issues a read request and then a write request for each beat, never both at once. A beat is 2^cfg_beat_log2 bytes. The number of pairs is ceil(cfg_nbytes / beat), and a byte count of 0 gives one pair.
- R3: When a loop starts with citer at 0, citer first loads cfg_biter. Each minor loop that ends with citer above 1 decrements citer by one.
- R4: A minor loop that ends with citer at 1 (or 0) completes the major loop. citer then reloads from cfg_biter, done_flag sets, and irq_major pulses for one cycle if cfg_major_irq_en is 1.
- R5: If cfg_half_irq_en is 1, irq_half pulses for one cycle when a decrement leaves citer equal to cfg_biter >> 1.
- R6: Stall code 2 inserts 4 idle cycles and code 3 inserts 8 idle cycles after every read and every write, including the last write. Codes 0 and 1 insert none. busy stays high through the stalls.
- R7: Link mode 1 pulses link_req at every minor loop end. Mode 2 pulses it only at major completion. Modes 0 and 3 never pulse it. link_ch carries cfg_link_ch with each pulse.
- R8: req_en sets on req_en_set and clears on req_en_clr. At major completion with cfg_auto_stop set, it clears by itself.
- R9: A minor loop starts when idle on hw_req with req_en set, or on sw_start regardless of req_en.
- R10: With cfg_buf_wr_en set, wr_buf is high during every write of a minor loop except the last one. With it clear, wr_buf stays low.
- R11: While halt is high no new minor loop starts, but a minor loop already running completes normally.
- R12: done_flag stays set until a done_clr pulse clears it.
- R13: A start request while a minor loop is running is ignored and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_nbytes | input | NB_W | Bytes per minor loop |
| cfg_beat_log2 | input | 2 | log2 of bytes per beat |
| cfg_biter | input | IT_W | Beginning iteration count |
| cfg_stall_code | input | 2 | Post-access stall code |
| cfg_link_mode | input | 2 | 0 none, 1 each minor end, 2 major only |
| cfg_link_ch | input | CH_W | Channel named by link pulses |
| cfg_major_irq_en | input | 1 | Enables the major-complete pulse |
| cfg_half_irq_en | input | 1 | Enables the half-way pulse |
| cfg_auto_stop | input | 1 | Clears req_en at major completion |
| cfg_buf_wr_en | input | 1 | Enables bufferable marking of writes |
| halt | input | 1 | Blocks new starts |
| req_en_set | input | 1 | Sets the request enable |
| req_en_clr | input | 1 | Clears the request enable |
| hw_req | input | 1 | Hardware request |
| sw_start | input | 1 | Software start pulse |
| done_clr | input | 1 | Write-one-to-clear for done_flag |
| rd_done | input | 1 | Read completion pulse |
| wr_done | input | 1 | Write completion pulse |
| rd_req | output | 1 | Read access request |
| wr_req | output | 1 | Write access request |
| wr_buf | output | 1 | Current write is bufferable |
| busy | output | 1 | A minor loop is in progress |
| req_en | output | 1 | Hardware request enable |
| done_flag | output | 1 | Sticky major-complete flag |
| citer | output | IT_W | Current iteration count |
| irq_major | output | 1 | Major-complete interrupt pulse |
| irq_half | output | 1 | Half-way interrupt pulse |
| link_req | output | 1 | Channel link pulse |
| link_ch | output | CH_W | Linked channel number |

## Verification
The assertions check on every cycle the properties that hold in any single cycle. These are: a completed read drops its request, a stall following an access keeps both strobes low, halt keeps an idle sequencer idle, and link pulses appear only after a minor loop end. They also check that major completion reloads the counter, sets done and drops the request enable when auto-stop is on. The bench scenarios are needed for properties that only show up across a whole loop. These are the exact beat count, the total number of stall cycles, the wr_buf marking on every write but the last, the half-way point, the number of hardware-triggered loops before auto-stop, and a start pulse inside a running loop being dropped.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RD    = 2'd1,
        ST_WR    = 2'd2,
        ST_STALL = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        LNK_NONE  = 2'd0,
        LNK_MINOR = 2'd1,
        LNK_MAJOR = 2'd2,
        LNK_RSVD  = 2'd3
    } link_mode_e;

    localparam int STALL_W = 4;

    // Idle cycles inserted after each access for a bandwidth code.
    function automatic logic [STALL_W-1:0] stall_len(input logic [1:0] code);
        case (code)
            2'd2:    return STALL_W'(4);
            2'd3:    return STALL_W'(8);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/dma_seq_stall.sv
module dma_seq_stall
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] code,
    output logic       expire
);
    logic [STALL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= stall_len(code);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - STALL_W'(1);
        end
    end

    assign expire = (cnt_q == STALL_W'(1));

    p_stall_armed_r6: assert property (@(posedge clk) disable iff (rst)
        (load && code[1]) |=> (cnt_q != '0));

endmodule

// File: rtl/dma_seq_iter.sv
module dma_seq_iter
    import dma_seq_pkg::*;
#(
    parameter int IT_W = 10,
    parameter int CH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            minor_end,
    input  logic [IT_W-1:0] cfg_biter,
    input  logic [1:0]      cfg_link_mode,
    input  logic [CH_W-1:0] cfg_link_ch,
    input  logic            cfg_major_irq_en,
    input  logic            cfg_half_irq_en,
    input  logic            done_clr,
    output logic [IT_W-1:0] citer,
    output logic            done_flag,
    output logic            irq_major,
    output logic            irq_half,
    output logic            link_req,
    output logic [CH_W-1:0] link_ch,
    output logic            major_end
);
    logic [IT_W-1:0] citer_q;
    logic [IT_W-1:0] dec_val;
    link_mode_e      mode;

    assign mode      = link_mode_e'(cfg_link_mode);
    assign dec_val   = citer_q - IT_W'(1);
    assign major_end = minor_end && (citer_q <= IT_W'(1));
    assign citer     = citer_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            citer_q   <= '0;
            done_flag <= 1'b0;
            irq_major <= 1'b0;
            irq_half  <= 1'b0;
            link_req  <= 1'b0;
            link_ch   <= '0;
        end else begin
            irq_major <= 1'b0;
            irq_half  <= 1'b0;
            link_req  <= 1'b0;
            if (start && citer_q == '0) begin
                citer_q <= cfg_biter;
            end
            if (minor_end) begin
                if (citer_q <= IT_W'(1)) begin
                    citer_q   <= cfg_biter;
                    irq_major <= cfg_major_irq_en;
                    if (mode == LNK_MINOR || mode == LNK_MAJOR) begin
                        link_req <= 1'b1;
                        link_ch  <= cfg_link_ch;
                    end
                end else begin
                    citer_q  <= dec_val;
                    irq_half <= cfg_half_irq_en && (dec_val == (cfg_biter >> 1));
                    if (mode == LNK_MINOR) begin
                        link_req <= 1'b1;
                        link_ch  <= cfg_link_ch;
                    end
                end
            end
            if (major_end) begin
                done_flag <= 1'b1;
            end else if (done_clr) begin
                done_flag <= 1'b0;
            end
        end
    end

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        major_end |=> (citer == $past(cfg_biter)) && done_flag);

    p_link_source_r7: assert property (@(posedge clk) disable iff (rst)
        link_req |-> $past(minor_end));

endmodule

// File: rtl/dma_loop_seq.sv
module dma_loop_seq
    import dma_seq_pkg::*;
#(
    parameter int NB_W = 16,
    parameter int IT_W = 10,
    parameter int CH_W = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NB_W-1:0] cfg_nbytes,
    input  logic [1:0]      cfg_beat_log2,
    input  logic [IT_W-1:0] cfg_biter,
    input  logic [1:0]      cfg_stall_code,
    input  logic [1:0]      cfg_link_mode,
    input  logic [CH_W-1:0] cfg_link_ch,
    input  logic            cfg_major_irq_en,
    input  logic            cfg_half_irq_en,
    input  logic            cfg_auto_stop,
    input  logic            cfg_buf_wr_en,
    input  logic            halt,
    input  logic            req_en_set,
    input  logic            req_en_clr,
    input  logic            hw_req,
    input  logic            sw_start,
    input  logic            done_clr,
    input  logic            rd_done,
    input  logic            wr_done,
    output logic            rd_req,
    output logic            wr_req,
    output logic            wr_buf,
    output logic            busy,
    output logic            req_en,
    output logic            done_flag,
    output logic [IT_W-1:0] citer,
    output logic            irq_major,
    output logic            irq_half,
    output logic            link_req,
    output logic [CH_W-1:0] link_ch
);
    seq_state_e      state_q, resume_q, after_wr;
    logic [NB_W-1:0] bytes_left_q;
    logic [NB_W-1:0] beat;
    logic            last_beat;
    logic            stall_on;
    logic            stall_load;
    logic            stall_expire;
    logic            start_ok;
    logic            minor_end;
    logic            major_end;
    logic            rd_fin;
    logic            wr_fin;

    assign beat       = NB_W'(1) << cfg_beat_log2;
    assign last_beat  = (bytes_left_q <= beat);
    assign stall_on   = (stall_len(cfg_stall_code) != '0);
    assign rd_fin     = (state_q == ST_RD) && rd_done;
    assign wr_fin     = (state_q == ST_WR) && wr_done;
    assign stall_load = (rd_fin || wr_fin) && stall_on;
    assign minor_end  = wr_fin && last_beat;
    assign start_ok   = (state_q == ST_IDLE) && !halt
                        && (sw_start || (hw_req && req_en));
    assign after_wr   = last_beat ? ST_IDLE : ST_RD;

    assign rd_req = (state_q == ST_RD);
    assign wr_req = (state_q == ST_WR);
    assign wr_buf = (state_q == ST_WR) && cfg_buf_wr_en && !last_beat;
    assign busy   = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            resume_q     <= ST_IDLE;
            bytes_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        state_q      <= ST_RD;
                        bytes_left_q <= cfg_nbytes;
                    end
                end
                ST_RD: begin
                    if (rd_done) begin
                        if (stall_on) begin
                            state_q  <= ST_STALL;
                            resume_q <= ST_WR;
                        end else begin
                            state_q <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (wr_done) begin
                        if (!last_beat) begin
                            bytes_left_q <= bytes_left_q - beat;
                        end
                        if (stall_on) begin
                            state_q  <= ST_STALL;
                            resume_q <= after_wr;
                        end else begin
                            state_q <= after_wr;
                        end
                    end
                end
                ST_STALL: begin
                    if (stall_expire) begin
                        state_q <= resume_q;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_en <= 1'b0;
        end else if (major_end && cfg_auto_stop) begin
            req_en <= 1'b0;
        end else if (req_en_clr) begin
            req_en <= 1'b0;
        end else if (req_en_set) begin
            req_en <= 1'b1;
        end
    end

    dma_seq_stall u_stall (
        .clk    (clk),
        .rst    (rst),
        .load   (stall_load),
        .code   (cfg_stall_code),
        .expire (stall_expire)
    );

    dma_seq_iter #(
        .IT_W (IT_W),
        .CH_W (CH_W)
    ) u_iter (
        .clk              (clk),
        .rst              (rst),
        .start            (start_ok),
        .minor_end        (minor_end),
        .cfg_biter        (cfg_biter),
        .cfg_link_mode    (cfg_link_mode),
        .cfg_link_ch      (cfg_link_ch),
        .cfg_major_irq_en (cfg_major_irq_en),
        .cfg_half_irq_en  (cfg_half_irq_en),
        .done_clr         (done_clr),
        .citer            (citer),
        .done_flag        (done_flag),
        .irq_major        (irq_major),
        .irq_half         (irq_half),
        .link_req         (link_req),
        .link_ch          (link_ch),
        .major_end        (major_end)
    );

    p_read_retires_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_done) |=> !rd_req);

    p_stall_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_done && stall_on) |=> (!rd_req && !wr_req && busy));

    p_halt_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && halt) |=> !busy);

    p_autostop_r8: assert property (@(posedge clk) disable iff (rst)
        (major_end && cfg_auto_stop) |=> !req_en);

endmodule

// File: tb/dma_loop_seq_tb.sv
module dma_loop_seq_tb_top;
    localparam int NB_W = 16;
    localparam int IT_W = 10;
    localparam int CH_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NB_W-1:0] cfg_nbytes = '0;
    logic [1:0]      cfg_beat_log2 = '0;
    logic [IT_W-1:0] cfg_biter = '0;
    logic [1:0]      cfg_stall_code = '0;
    logic [1:0]      cfg_link_mode = '0;
    logic [CH_W-1:0] cfg_link_ch = '0;
    logic cfg_major_irq_en = 0, cfg_half_irq_en = 0, cfg_auto_stop = 0, cfg_buf_wr_en = 0;
    logic halt = 0, req_en_set = 0, req_en_clr = 0, hw_req = 0, sw_start = 0, done_clr = 0;
    logic rd_done = 0, wr_done = 0;
    logic rd_req, wr_req, wr_buf, busy, req_en, done_flag;
    logic [IT_W-1:0] citer;
    logic irq_major, irq_half, link_req;
    logic [CH_W-1:0] link_ch;

    always #5 clk = ~clk;

    dma_loop_seq #(.NB_W(NB_W), .IT_W(IT_W), .CH_W(CH_W)) dut_i (
        .clk(clk), .rst(rst), .cfg_nbytes(cfg_nbytes), .cfg_beat_log2(cfg_beat_log2),
        .cfg_biter(cfg_biter), .cfg_stall_code(cfg_stall_code), .cfg_link_mode(cfg_link_mode),
        .cfg_link_ch(cfg_link_ch), .cfg_major_irq_en(cfg_major_irq_en),
        .cfg_half_irq_en(cfg_half_irq_en), .cfg_auto_stop(cfg_auto_stop),
        .cfg_buf_wr_en(cfg_buf_wr_en), .halt(halt), .req_en_set(req_en_set),
        .req_en_clr(req_en_clr), .hw_req(hw_req), .sw_start(sw_start), .done_clr(done_clr),
        .rd_done(rd_done), .wr_done(wr_done), .rd_req(rd_req), .wr_req(wr_req),
        .wr_buf(wr_buf), .busy(busy), .req_en(req_en), .done_flag(done_flag), .citer(citer),
        .irq_major(irq_major), .irq_half(irq_half), .link_req(link_req), .link_ch(link_ch));

    int n_checks = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0, n_buf = 0, n_gap = 0, n_major = 0, n_half = 0, n_link = 0, n_start = 0;
    int last_link_ch = 0;
    int rlat = 0, wlat = 0;
    bit prev_busy = 0;
    int e_citer = 0;
    bit e_done = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // bus responder with random latency; counts completed handshakes
    always @(negedge clk) begin
        if (rd_done) begin
            rd_done = 0; n_rd++;
        end else if (rd_req) begin
            if (rlat == 0) begin rd_done = 1; rlat = $urandom % 3; end
            else rlat--;
        end
        if (wr_done) begin
            wr_done = 0; n_wr++;
        end else if (wr_req) begin
            if (wlat == 0) begin
                wr_done = 1; wlat = $urandom % 3;
                if (wr_buf) n_buf++;
            end else wlat--;
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !rd_req && !wr_req) n_gap++;
            if (irq_major) n_major++;
            if (irq_half) n_half++;
            if (link_req) begin n_link++; last_link_ch = int'(link_ch); end
            if (busy && !prev_busy) n_start++;
            prev_busy = busy;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "WDOG", "watchdog expired", cycles, 150000);
            finish_run();
        end
    end

    function automatic int stall_model(input int code);
        return (code == 2) ? 4 : (code == 3) ? 8 : 0;
    endfunction

    task automatic wait_idle();
        int g = 0;
        while (busy && g < 5000) begin @(negedge clk); g++; end
        chk(g < 5000, "R2", "loop did not finish", g, 5000);
    endtask

    // poke: 0 none, 1 raise halt mid-loop, 2 extra sw_start mid-loop
    task automatic do_minor(input int poke);
        int r0 = n_rd, w0 = n_wr, b0 = n_buf, g0 = n_gap, m0 = n_major;
        int h0 = n_half, l0 = n_link, s0 = n_start;
        int beat = 1 << cfg_beat_log2;
        int nb = int'(cfg_nbytes);
        int acc = (nb == 0) ? 1 : (nb + beat - 1) / beat;
        int st = stall_model(int'(cfg_stall_code));
        int bit_ = int'(cfg_biter);
        int c = (e_citer == 0) ? bit_ : e_citer;
        int lm = int'(cfg_link_mode);
        int exp_major = 0, exp_half = 0, exp_link = 0;
        if (c <= 1) begin
            e_citer = bit_; e_done = 1;
            exp_major = cfg_major_irq_en ? 1 : 0;
            exp_link = (lm == 1 || lm == 2) ? 1 : 0;
        end else begin
            e_citer = c - 1;
            exp_half = (cfg_half_irq_en && (c - 1) == (bit_ >> 1)) ? 1 : 0;
            exp_link = (lm == 1) ? 1 : 0;
        end
        @(negedge clk); sw_start = 1;
        @(negedge clk); sw_start = 0;
        if (poke == 1) halt = 1;
        if (poke == 2) begin sw_start = 1; @(negedge clk); sw_start = 0; end
        wait_idle();
        repeat (3) @(negedge clk);
        #1;
        halt = 0;
        chk(n_start - s0 == 1, "R13", "starts per loop", n_start - s0, 1);
        chk(n_rd - r0 == acc, "R2", "reads", n_rd - r0, acc);
        chk(n_wr - w0 == acc, "R2", "writes", n_wr - w0, acc);
        chk(n_gap - g0 == 2 * acc * st, "R6", "stall cycles", n_gap - g0, 2 * acc * st);
        chk(n_buf - b0 == (cfg_buf_wr_en ? acc - 1 : 0), "R10", "bufferable writes",
            n_buf - b0, cfg_buf_wr_en ? acc - 1 : 0);
        chk(int'(citer) == e_citer, "R3", "citer", int'(citer), e_citer);
        chk(n_major - m0 == exp_major, "R4", "major irq", n_major - m0, exp_major);
        chk(done_flag == e_done, "R12", "done flag", done_flag, e_done);
        chk(n_half - h0 == exp_half, "R5", "half irq", n_half - h0, exp_half);
        chk(n_link - l0 == exp_link, "R7", "link pulses", n_link - l0, exp_link);
        if (exp_link == 1)
            chk(last_link_ch == int'(cfg_link_ch), "R7", "link channel", last_link_ch, int'(cfg_link_ch));
    endtask

    task automatic pulse_done_clr();
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
        @(negedge clk); #1;
        e_done = 0;
        chk(done_flag == 0, "R12", "done after clear", done_flag, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        #1;
        // R1 reset state
        chk(!busy && !rd_req && !wr_req && !wr_buf, "R1", "idle strobes", busy, 0);
        chk(!req_en && !done_flag, "R1", "enable and done", req_en, 0);
        chk(citer == 0 && !irq_major && !irq_half && !link_req, "R1", "counter and pulses", int'(citer), 0);
        @(negedge clk); rst = 0;

        // R9/R8: hardware request, auto-stop after three loops
        cfg_nbytes = 16'd8; cfg_beat_log2 = 2'd1; cfg_biter = 10'd3;
        cfg_auto_stop = 1; cfg_major_irq_en = 1;
        hw_req = 1;
        repeat (3) @(negedge clk);
        chk(n_start == 0, "R9", "hw_req without enable", n_start, 0);
        req_en_set = 1; @(negedge clk); req_en_set = 0;
        begin
            int g = 0;
            while (!(done_flag && !busy) && g < 3000) begin @(negedge clk); g++; end
        end
        repeat (6) @(negedge clk);
        #1;
        hw_req = 0;
        chk(n_start == 3, "R9", "hw-triggered loops", n_start, 3);
        chk(n_rd == 12, "R2", "reads over major", n_rd, 12);
        chk(req_en == 0, "R8", "auto-stop cleared enable", req_en, 0);
        chk(int'(citer) == 3, "R4", "reload", int'(citer), 3);
        chk(n_major == 1, "R4", "major irq", n_major, 1);
        e_citer = 3; e_done = 1;
        pulse_done_clr();
        req_en_set = 1; @(negedge clk); req_en_set = 0;
        req_en_clr = 1; @(negedge clk); req_en_clr = 0; #1;
        chk(req_en == 0, "R8", "req_en_clr", req_en, 0);

        // R11: halt blocks software start
        halt = 1;
        @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
        repeat (4) @(negedge clk); #1;
        chk(n_start == 3 && !busy, "R11", "start while halted", n_start, 3);
        halt = 0;

        // R11 halt mid-loop, R13 start mid-loop, R6 long stall, R10 buffered
        cfg_stall_code = 2'd3; cfg_buf_wr_en = 1; cfg_nbytes = 16'd13; cfg_beat_log2 = 2'd2;
        do_minor(1);
        do_minor(2);

        // R5/R7 directed half and minor-link run
        cfg_biter = 10'd4; cfg_half_irq_en = 1; cfg_link_mode = 2'd1; cfg_link_ch = 5'd17;
        cfg_stall_code = 2'd2; cfg_nbytes = 16'd0;
        pulse_done_clr();
        e_citer = int'(citer);
        for (int i = 0; i < 4; i++) do_minor(0);
        cfg_link_mode = 2'd2;
        for (int i = 0; i < 4; i++) do_minor(0);

        // random phase
        for (int i = 0; i < 40; i++) begin
            cfg_nbytes       = NB_W'($urandom % 25);
            cfg_beat_log2    = 2'($urandom % 4);
            cfg_stall_code   = 2'($urandom % 4);
            cfg_link_mode    = 2'($urandom % 4);
            cfg_link_ch      = CH_W'($urandom);
            cfg_major_irq_en = 1'($urandom % 2);
            cfg_half_irq_en  = 1'($urandom % 2);
            cfg_buf_wr_en    = 1'($urandom % 2);
            if ($urandom % 5 == 0) cfg_biter = IT_W'(1 + $urandom % 6);
            if ($urandom % 4 == 0) pulse_done_clr();
            do_minor(0);
        end
        finish_run();
    end
endmodule